// File: doc/BRIEF.md
# Unaligned Internet Checksum Engine

This block sums a byte buffer of arbitrary start address and length into the 16-bit one's-complement Internet checksum (the sum only; the caller complements it if needed). A start pulse supplies a byte address and a signed byte count. The engine reads 64-bit little-endian words from 8-byte-aligned addresses over a plain read port with a fixed response latency, blanks the bytes that fall outside the buffer in the first and last words, and accumulates with end-around carry. At the end it reduces the 64-bit sum to 16 bits and presents it with a one-cycle done pulse.

Reads go out in the order first word, last word, then the middle words in rising address order. Middle words are spread over two accumulator lanes that collect their carries in counters rather than folding them in every step; an odd middle count is evened out by taking one word on its own first. Because each 16-bit pair in the sum is aligned to even absolute addresses, a buffer that starts at an odd address has its result bytes exchanged so that the pairing starts at the first buffer byte.

Top module: `csum_engine`

## Requirements
- R1: A start with a byte count of zero or less (count read as two's complement) gives done one cycle later with result 0 and no read request.
- R2: A start pulse while busy is high has no effect on the job in progress, its reads or its result.
- R3: Every read address is a multiple of 8 between the word holding the first byte and the word holding the last byte; each such word is read exactly once.
- R4: Bytes of the first word below the start address do not contribute to the result.
- R5: Bytes of the last word at or beyond start plus count do not contribute to the result.
- R6: When the whole buffer lies inside one 8-byte word, exactly one read is made and both blankings apply to it.
- R7: For an even start address the result equals the one's-complement sum, folded to 16 bits with end-around carry, of the buffer taken as little-endian 16-bit pairs (first byte low, a lone final byte as low byte); it is zero only when every buffer byte is zero.
- R8: For an odd start address the result is the R7 sum with its two bytes exchanged, i.e. the pairing still starts at the first buffer byte.
- R9: After reset busy, done, read request and result are 0; busy is high from the cycle after an accepted non-empty start until done; done lasts one cycle and the result holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken only while not busy) |
| start_addr | input | AW | Byte address of the first buffer byte |
| byte_len | input | LW | Signed byte count |
| rd_en | output | 1 | Read request |
| rd_addr | output | AW | 8-byte-aligned read address |
| rd_data | input | 64 | Read data, LAT cycles after the request |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| result | output | 16 | Folded one's-complement sum |

## Verification
The bench sweeps every start offset within a word against every length from 1 to 64 over random memory, so that garbage always sits next to the buffer: a wrong head or tail mask then shows up as a wrong sum, and a wrong word count or stray address shows up in the read tally. Odd offsets catch a missing or misplaced byte exchange, and single-word cases catch a design that reads the last word separately or forgets to merge the two masks. An all-ones memory forces a carry on nearly every addition, exposing any dropped lane carry counter or a non-wrapping fold. Zero and negative counts, and a second start issued mid-job, check that no read leaks out and that the running job is not disturbed.

// File: rtl/csum_pkg.sv
package csum_pkg;

  typedef enum logic [2:0] {
    K_HEAD, K_TAIL, K_SOLO, K_LANE0, K_LANE1
  } word_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LAUNCH, PH_RUN, PH_CARRY, PH_MERGE, PH_FOLD
  } phase_t;

  // 64-bit add with the carry wrapped back into bit 0
  function automatic logic [63:0] oc_add(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[63:0] + {63'd0, s[64]};
  endfunction

  // 64 -> 32 -> three 16-bit end-around folds
  function automatic logic [15:0] fold_sum(input logic [63:0] x);
    logic [32:0] h;
    logic [17:0] f;
    h = {1'b0, x[63:32]} + {1'b0, x[31:0]};
    f = {2'b00, h[15:0]} + {1'b0, h[32:16]};
    f = {2'b00, f[15:0]} + {16'd0, f[17:16]};
    f = {2'b00, f[15:0]} + {16'd0, f[17:16]};
    return f[15:0];
  endfunction

endpackage

// File: rtl/csum_plan.sv
module csum_plan #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int CW = AW - 2
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] nbytes,
  output logic [AW-1:0] first_wa,
  output logic [AW-1:0] last_wa,
  output logic [CW-1:0] nwords,
  output logic [63:0]   head_mask,
  output logic [63:0]   tail_mask,
  output logic          empty
);
  logic [AW-1:0] end_a, last_b, span;
  logic [2:0]    tail_gap;
  logic [63:0]   hm, tm;

  always_comb begin
    empty    = ($signed(nbytes) <= 0);
    end_a    = base + AW'(nbytes);
    last_b   = end_a - AW'(1);
    first_wa = {base[AW-1:3], 3'b000};
    last_wa  = {last_b[AW-1:3], 3'b000};
    span     = last_wa - first_wa;
    nwords   = CW'(span >> 3) + CW'(1);
    tail_gap = 3'd0 - end_a[2:0];
    hm       = {64{1'b1}} << {base[2:0], 3'b000};
    tm       = {64{1'b1}} >> {tail_gap, 3'b000};
    head_mask = (first_wa == last_wa) ? (hm & tm) : hm;
    tail_mask = tm;
  end
endmodule

// File: rtl/csum_fetch.sv
module csum_fetch
  import csum_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = AW - 2,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] first_wa,
  input  logic [AW-1:0] last_wa,
  input  logic [CW-1:0] nwords,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output word_kind_t    rsp_kind
);
  logic          active;
  logic [CW-1:0] idx, mid_cnt, mid_idx, pair_pos;
  logic          mid_odd;
  word_kind_t    kind_n, kind_q, k0;
  logic [AW-1:0] addr_n;
  logic          v0;

  always_comb begin
    mid_cnt  = nwords - CW'(2);
    mid_idx  = idx - CW'(2);
    mid_odd  = mid_cnt[0];
    pair_pos = mid_idx - {{(CW-1){1'b0}}, mid_odd};
    addr_n   = first_wa + (AW'(idx - CW'(1)) << 3);
    kind_n   = pair_pos[0] ? K_LANE1 : K_LANE0;
    if (idx == '0) begin
      kind_n = K_HEAD;
      addr_n = first_wa;
    end else if (idx == CW'(1)) begin
      kind_n = K_TAIL;
      addr_n = last_wa;
    end else if (mid_odd && mid_idx == '0) begin
      kind_n = K_SOLO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      kind_q  <= K_HEAD;
    end else begin
      rd_en <= 1'b0;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        rd_en   <= 1'b1;
        rd_addr <= addr_n;
        kind_q  <= kind_n;
        idx     <= idx + CW'(1);
        if (idx == nwords - CW'(1)) active <= 1'b0;
      end
    end
  end

  // tag pipeline matched to the memory latency
  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0;
      k0 <= K_HEAD;
    end else begin
      v0 <= rd_en;
      k0 <= kind_q;
    end
  end

  generate
    if (LAT == 1) begin : g_lat1
      assign rsp_valid = v0;
      assign rsp_kind  = k0;
    end else begin : g_lat2
      logic       v1;
      word_kind_t k1;
      always_ff @(posedge clk) begin
        if (rst) begin
          v1 <= 1'b0;
          k1 <= K_HEAD;
        end else begin
          v1 <= v0;
          k1 <= k0;
        end
      end
      assign rsp_valid = v1;
      assign rsp_kind  = k1;
    end
  endgenerate

  // R3
  fetch_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr >= first_wa && rd_addr <= last_wa));
endmodule

// File: rtl/csum_accum.sv
module csum_accum
  import csum_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        in_valid,
  input  word_kind_t  in_kind,
  input  logic [63:0] in_data,
  input  logic [63:0] head_mask,
  input  logic [63:0] tail_mask,
  input  logic        fin_carry,
  input  logic        fin_merge,
  output logic [63:0] total
);
  logic [63:0]   lane0, lane1, w;
  logic [CW-1:0] cy0, cy1;
  logic [64:0]   s0, s1;

  always_comb begin
    w = in_data;
    if (in_kind == K_HEAD) w = in_data & head_mask;
    if (in_kind == K_TAIL) w = in_data & tail_mask;
    s0 = {1'b0, lane0} + {1'b0, w};
    s1 = {1'b0, lane1} + {1'b0, w};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lane0 <= '0;
      lane1 <= '0;
      cy0   <= '0;
      cy1   <= '0;
    end else if (fin_merge) begin
      lane0 <= oc_add(lane0, lane1);
    end else if (fin_carry) begin
      lane0 <= oc_add(lane0, 64'(cy0));
      lane1 <= oc_add(lane1, 64'(cy1));
    end else if (in_valid) begin
      case (in_kind)
        K_LANE0: begin
          lane0 <= s0[63:0];
          cy0   <= cy0 + {{(CW-1){1'b0}}, s0[64]};
        end
        K_LANE1: begin
          lane1 <= s1[63:0];
          cy1   <= cy1 + {{(CW-1){1'b0}}, s1[64]};
        end
        default: lane0 <= oc_add(lane0, w);
      endcase
    end
  end

  assign total = lane0;

  // R7
  merge_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_merge && (lane0 != '0 || lane1 != '0)) |=> (total != '0));
endmodule

// File: rtl/csum_engine.sv
module csum_engine
  import csum_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LW  = 16,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] byte_len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [63:0]   rd_data,
  output logic          busy,
  output logic          done,
  output logic [15:0]   result
);
  localparam int CW = AW - 2;

  logic [AW-1:0] p_first, p_last, first_q, last_q;
  logic [CW-1:0] p_nwords, nwords_q, rx_cnt;
  logic [63:0]   p_hmask, p_tmask, hmask_q, tmask_q, total;
  logic          p_empty, odd_q, done_q, rsp_valid;
  logic [15:0]   result_q, folded;
  word_kind_t    rsp_kind;
  phase_t        state;

  csum_plan #(.AW(AW), .LW(LW), .CW(CW)) u_plan (
    .base(start_addr), .nbytes(byte_len), .first_wa(p_first), .last_wa(p_last),
    .nwords(p_nwords), .head_mask(p_hmask), .tail_mask(p_tmask), .empty(p_empty)
  );

  csum_fetch #(.AW(AW), .CW(CW), .LAT(LAT)) u_fetch (
    .clk(clk), .rst(rst), .go(state == PH_LAUNCH), .first_wa(first_q), .last_wa(last_q),
    .nwords(nwords_q), .rd_en(rd_en), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind)
  );

  csum_accum #(.CW(CW)) u_acc (
    .clk(clk), .rst(rst), .clear(state == PH_LAUNCH), .in_valid(rsp_valid),
    .in_kind(rsp_kind), .in_data(rd_data), .head_mask(hmask_q), .tail_mask(tmask_q),
    .fin_carry(state == PH_CARRY), .fin_merge(state == PH_MERGE), .total(total)
  );

  always_comb folded = fold_sum(total);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_IDLE;
      done_q   <= 1'b0;
      result_q <= '0;
      first_q  <= '0;
      last_q   <= '0;
      nwords_q <= '0;
      hmask_q  <= '0;
      tmask_q  <= '0;
      odd_q    <= 1'b0;
      rx_cnt   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        PH_IDLE: if (start) begin
          if (p_empty) begin
            done_q   <= 1'b1;
            result_q <= '0;
          end else begin
            first_q  <= p_first;
            last_q   <= p_last;
            nwords_q <= p_nwords;
            hmask_q  <= p_hmask;
            tmask_q  <= p_tmask;
            odd_q    <= start_addr[0];
            rx_cnt   <= '0;
            state    <= PH_LAUNCH;
          end
        end
        PH_LAUNCH: state <= PH_RUN;
        PH_RUN: if (rsp_valid) begin
          rx_cnt <= rx_cnt + CW'(1);
          if (rx_cnt == nwords_q - CW'(1)) state <= PH_CARRY;
        end
        PH_CARRY: state <= PH_MERGE;
        PH_MERGE: state <= PH_FOLD;
        default: begin
          result_q <= odd_q ? {folded[7:0], folded[15:8]} : folded;
          done_q   <= 1'b1;
          state    <= PH_IDLE;
        end
      endcase
    end
  end

  assign busy   = (state != PH_IDLE);
  assign done   = done_q;
  assign result = result_q;

  // R1
  read_in_job_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(first_q) && $stable(nwords_q) && $stable(odd_q)));
  // R3
  rsp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (state == PH_RUN && rx_cnt < nwords_q));
endmodule

// File: tb/sim_csum_engine.sv
module sim_csum_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] byte_len = '0;
  logic          rd_en, busy, done;
  logic [AW-1:0] rd_addr;
  logic [63:0]   rd_data;
  logic [15:0]   result;

  logic [7:0]  mem [256];
  logic [63:0] pipe1 = '0, pipe2 = '0;
  int nreads, bad_reads, exp_lo, exp_hi;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csum_engine #(.AW(AW), .LW(LW), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .byte_len(byte_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .result(result)
  );

  function automatic logic [63:0] word_at(input int a);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = mem[(a + b) & 255];
    return w;
  endfunction

  always @(posedge clk) begin
    pipe1 <= rd_en ? word_at(int'(rd_addr)) : 64'h0123_4567_89AB_CDEF;
    pipe2 <= pipe1;
    if (rd_en) begin
      nreads = nreads + 1;
      if ((rd_addr & 16'h7) != 0 || int'(rd_addr) < exp_lo || int'(rd_addr) > exp_hi)
        bad_reads = bad_reads + 1;
    end
  end
  assign rd_data = (LAT == 1) ? pipe1 : pipe2;

  function automatic int ref_sum(input int a, input int n);
    int s = 0;
    for (int i = 0; i < n; i++)
      s += (i % 2 == 0) ? int'(mem[(a + i) & 255]) : (int'(mem[(a + i) & 255]) << 8);
    while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_job(input int a, input int n, input bit poke, input string rtag,
                         input string ntag);
    int exp_r, exp_n, cyc;
    bit got;
    exp_lo = a & ~7;
    exp_hi = (a + n - 1) & ~7;
    exp_n  = (n <= 0) ? 0 : ((exp_hi - exp_lo) >> 3) + 1;
    exp_r  = (n <= 0) ? 0 : ref_sum(a, n);
    nreads = 0;
    bad_reads = 0;
    @(negedge clk);
    start = 1'b1;
    start_addr = AW'(a);
    byte_len = LW'(n);
    @(negedge clk);
    start = 1'b0;
    if (n > 0) chk(busy == 1'b1, "R9 busy", int'(busy), 1);
    got = 1'b0;
    cyc = 0;
    while (!got && cyc < 400) begin
      if (done) got = 1'b1;
      else begin
        if (poke && cyc == 1) begin
          start = 1'b1;
          start_addr = AW'(a ^ 5);
          byte_len = LW'(3);
        end else start = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    chk(got, "R9 done", int'(got), 1);
    if (n <= 0) chk(cyc == 0, "R1 latency", cyc, 0);
    chk(int'(result) == exp_r, rtag, int'(result), exp_r);
    chk(nreads == exp_n, ntag, nreads, exp_n);
    chk(bad_reads == 0, "R3 address", bad_reads, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse", int'(done), 0);
    chk(int'(result) == exp_r, "R9 hold", int'(result), exp_r);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string rt, nt;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rd_en == 1'b0, "R9 reset", int'({busy, done, rd_en}), 0);
    chk(result == 16'h0, "R9 reset result", int'(result), 0);

    // R1: empty and negative counts
    run_job(41, 0, 1'b0, "R1 result", "R1 reads");
    run_job(44, -3, 1'b0, "R1 result", "R1 reads");

    // offset x length sweep over random memory
    for (int off = 0; off < 8; off++) begin
      for (int n = 1; n <= 64; n++) begin
        if (off % 2 == 1) rt = "R8 result";
        else if (off + n <= 8) rt = "R6 result";
        else if (off != 0) rt = "R4 result";
        else if (n % 8 != 0) rt = "R5 result";
        else rt = "R7 result";
        nt = (off + n <= 8) ? "R6 reads" : "R3 reads";
        run_job(40 + off, n, 1'b0, rt, nt);
      end
    end

    // R2: start during a job
    for (int k = 0; k < 6; k++)
      run_job(40 + k, 20 + 7 * k, 1'b1, "R2 result", "R2 reads");

    // R7: all-ones memory, carry on nearly every add
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    for (int n = 1; n <= 64; n++) begin
      run_job(40, n, 1'b0, "R7 carry", "R3 reads");
      run_job(43, n, 1'b0, "R8 carry", "R3 reads");
    end

    // R7: all-zero buffer inside nonzero surroundings
    for (int i = 48; i < 80; i++) mem[i] = 8'h00;
    run_job(50, 20, 1'b0, "R7 zero", "R3 reads");
    run_job(48, 32, 1'b0, "R7 zero", "R3 reads");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule